// File: doc/BRIEF.md
# CPU Double-Speed Switch Register

This block holds the clock-speed setting of a handheld CPU that can run at a base clock-enable rate or at twice that rate. Software changes speed in two steps. First it writes the register with bit 0 set, which arms a pending change. Then it executes its STOP instruction. The STOP decoder outside this block raises `stopReq`, and on that update the speed bit flips and the pending request clears.

The block selects which of two externally generated clock-enable pulses drives the CPU. It also reports the current speed on `fastSpeed` and returns a status byte on reads. The register responds only when the device is a color model and is running in color mode. In every other case, writes and STOP have no effect on it and reads return all ones. All updates are taken on the double-rate clock enable. Reset is synchronous and active low.

Top module: `speed_switch_reg`

## Requirements
- R1: While `rstN` is low, the speed bit and the arm bit are cleared on each clock edge. After reset the read-back byte is 0x7E and `fastSpeed` is 0.
- R2: An access write loads `wrData[0]` into the arm bit. An access write is a clock edge with `ceDouble`, `regSel`, `regWr`, `colorModel` and `colorMode` all high. Bits 7..1 of `wrData` are ignored.
- R3: When `regSel`, `colorModel` and `colorMode` are all high, `rdData` is {speed bit in bit 7, ones in bits 6..1, arm bit in bit 0}. The value is combinational.
- R4: A commit toggles the speed bit and clears the arm bit on the same clock edge. A commit is an edge with `ceDouble`, `colorModel`, `colorMode`, `stopReq` and the arm bit all high.
- R5: `stopReq` while the arm bit is 0 leaves the speed bit unchanged.
- R6: On an edge with `ceDouble` low, neither a write nor `stopReq` changes the speed bit or the arm bit.
- R7: With `colorModel` or `colorMode` low, the following hold:
  - writes and `stopReq` change neither bit;
  - `rdData` is 0xFF.
- R8: When an access write and a commit fall on the same edge, the commit wins and the arm bit ends at 0.
- R9: `cpuCe` equals `ceDouble` while the speed bit is 1, and equals `ceBase` otherwise.
- R10: When `regSel` is low, `rdData` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| ceBase | input | 1 | Base-rate clock-enable pulse |
| ceDouble | input | 1 | Double-rate clock-enable pulse; all updates are taken on it |
| colorModel | input | 1 | Device is a color model |
| colorMode | input | 1 | Device is running in color mode |
| regSel | input | 1 | CPU address selects this register |
| regWr | input | 1 | CPU write strobe |
| wrData | input | 8 | CPU write data; only bit 0 is used |
| stopReq | input | 1 | CPU is executing STOP |
| rdData | output | 8 | Read-back byte |
| fastSpeed | output | 1 | Current speed bit (1 = double rate) |
| cpuCe | output | 1 | Clock enable selected for the CPU |

## Verification
The assertions assume that every input is a clean two-state value that changes only away from the rising clock edge. They also assume that `rstN` is low at the first edge, because the reset property looks one cycle past a reset edge. The bench meets these assumptions by driving all inputs on the falling edge and holding reset for several cycles at start. Its random phase draws the clock enables, select, write, data and STOP independently. It keeps the access qualifiers high most of the time, so that commits, simultaneous write-and-commit edges and gated edges all occur often.

// File: rtl/speed_switch_pkg.sv
package speed_switch_pkg;
  typedef struct packed {
    logic armLoad;
    logic armValue;
    logic commit;
    logic readEn;
  } spdStrobe_t;
endpackage

// File: rtl/speed_switch_ctrl.sv
module speed_switch_ctrl
  import speed_switch_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ARM_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceDouble,
  input  logic              colorModel,
  input  logic              colorMode,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stopReq,
  input  logic              armQ,
  output spdStrobe_t        strobe
);
  logic accessOk;
  logic wrHit;

  always_comb begin
    accessOk        = colorModel & colorMode;
    wrHit           = ceDouble & regSel & regWr & accessOk;
    strobe.commit   = ceDouble & accessOk & armQ & stopReq;
    // the commit takes priority over a write on the same edge
    strobe.armLoad  = wrHit & ~strobe.commit;
    strobe.armValue = wrData[ARM_BIT];
    strobe.readEn   = regSel & accessOk;
  end

  // R8: a write never loads the arm bit on an edge that commits
  assert_commit_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ceDouble && regSel && regWr && colorModel && colorMode && armQ && stopReq)
      |-> (strobe.commit && !strobe.armLoad));

  // R6: no strobe fires without the double-rate enable
  assert_no_ce_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ceDouble |-> (!strobe.commit && !strobe.armLoad));
endmodule

// File: rtl/speed_switch_dp.sv
module speed_switch_dp
  import speed_switch_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SPEED_BIT = 7,
  parameter int ARM_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceBase,
  input  logic              ceDouble,
  input  spdStrobe_t        strobe,
  output logic              speedQ,
  output logic              armQ,
  output logic [DATA_W-1:0] rdData,
  output logic              cpuCe
);
  localparam logic [DATA_W-1:0] IDLE_READ = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      speedQ <= 1'b0;
      armQ   <= 1'b0;
    end else if (strobe.commit) begin
      speedQ <= ~speedQ;
      armQ   <= 1'b0;
    end else if (strobe.armLoad) begin
      armQ   <= strobe.armValue;
    end
  end

  always_comb begin
    rdData = IDLE_READ;
    if (strobe.readEn) begin
      rdData[SPEED_BIT] = speedQ;
      rdData[ARM_BIT]   = armQ;
    end
  end

  assign cpuCe = speedQ ? ceDouble : ceBase;

  // R1: reset clears both bits
  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> (!speedQ && !armQ));

  // R4: a commit flips speed and clears arm
  assert_commit_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> ((speedQ != $past(speedQ)) && !armQ));

  // R6: without a strobe the state holds
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.commit && !strobe.armLoad) |=> ($stable(speedQ) && $stable(armQ)));

  // R9: no enable at the input means no enable to the CPU
  assert_ce_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ceBase && !ceDouble) |-> !cpuCe);
endmodule

// File: rtl/speed_switch_reg.sv
module speed_switch_reg
  import speed_switch_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SPEED_BIT = 7,
  parameter int ARM_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceBase,
  input  logic              ceDouble,
  input  logic              colorModel,
  input  logic              colorMode,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stopReq,
  output logic [DATA_W-1:0] rdData,
  output logic              fastSpeed,
  output logic              cpuCe
);
  spdStrobe_t strobe;
  logic       armQ;
  logic       speedQ;

  speed_switch_ctrl #(.DATA_W(DATA_W), .ARM_BIT(ARM_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .ceDouble(ceDouble), .colorModel(colorModel),
    .colorMode(colorMode), .regSel(regSel), .regWr(regWr), .wrData(wrData),
    .stopReq(stopReq), .armQ(armQ), .strobe(strobe)
  );

  speed_switch_dp #(.DATA_W(DATA_W), .SPEED_BIT(SPEED_BIT), .ARM_BIT(ARM_BIT)) dp_i (
    .clk(clk), .rstN(rstN), .ceBase(ceBase), .ceDouble(ceDouble), .strobe(strobe),
    .speedQ(speedQ), .armQ(armQ), .rdData(rdData), .cpuCe(cpuCe)
  );

  assign fastSpeed = speedQ;

  // R7: gated edges leave the speed untouched
  assert_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(colorModel && colorMode) |=> $stable(fastSpeed));

  // R3: the read-back shows the speed bit and ones in the middle
  assert_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && colorModel && colorMode) |->
      ((rdData[SPEED_BIT] == fastSpeed) && (&rdData[SPEED_BIT-1:ARM_BIT+1])));
endmodule

// File: tb/speed_switch_reg_tb_top.sv
module speed_switch_reg_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceBase = 1'b0, ceDouble = 1'b0, colorModel = 1'b1, colorMode = 1'b1;
  logic       regSel = 1'b0, regWr = 1'b0, stopReq = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       fastSpeed, cpuCe;

  int checks = 0;
  int failures = 0;
  logic mSpeed = 1'b0;
  logic mArm = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  speed_switch_reg dut_i (
    .clk(clk), .rstN(rstN), .ceBase(ceBase), .ceDouble(ceDouble),
    .colorModel(colorModel), .colorMode(colorMode), .regSel(regSel),
    .regWr(regWr), .wrData(wrData), .stopReq(stopReq),
    .rdData(rdData), .fastSpeed(fastSpeed), .cpuCe(cpuCe)
  );

  function automatic logic [7:0] expRead(logic sp, logic ar);
    if (regSel && colorModel && colorMode) return {sp, 6'h3f, ar};
    return 8'hff;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(logic cb, logic cd, logic sel, logic wr, logic [7:0] d,
                       logic st, logic cm, logic md);
    ceBase = cb; ceDouble = cd; regSel = sel; regWr = wr; wrData = d;
    stopReq = st; colorModel = cm; colorMode = md;
  endtask

  // inputs already driven at a falling edge; check comb, step, check state
  task automatic cycle(string tag);
    logic nSpeed, nArm, en;
    #1;
    check({tag, "/R3 read"}, rdData, expRead(mSpeed, mArm));
    check({tag, "/R9 cpuCe"}, {7'd0, cpuCe}, {7'd0, mSpeed ? ceDouble : ceBase});
    en = colorModel && colorMode;
    nSpeed = mSpeed; nArm = mArm;
    if (ceDouble && en && mArm && stopReq) begin
      nSpeed = ~mSpeed; nArm = 1'b0;
    end else if (ceDouble && en && regSel && regWr) begin
      nArm = wrData[0];
    end
    @(posedge clk);
    @(negedge clk);
    mSpeed = nSpeed; mArm = nArm;
    check({tag, " speed"}, {7'd0, fastSpeed}, {7'd0, mSpeed});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    drive(0, 0, 1, 0, 8'h00, 0, 1, 1);
    #1;
    check("R1 reset read", rdData, 8'h7e);
    check("R1 reset speed", {7'd0, fastSpeed}, 8'd0);
    @(negedge clk);
    // R2: arm with high bits set, upper bits ignored
    drive(0, 1, 1, 1, 8'hFE, 0, 1, 1); cycle("R2 write0");
    drive(0, 1, 1, 1, 8'h01, 0, 1, 1); cycle("R2 arm");
    drive(0, 0, 1, 0, 8'h00, 0, 1, 1); cycle("R2 readback");
    check("R2 arm bit", rdData, 8'h7f);
    // R6: stop without double enable
    drive(1, 0, 1, 0, 8'h00, 1, 1, 1); cycle("R6 noce");
    // R4: commit
    drive(1, 1, 1, 0, 8'h00, 1, 1, 1); cycle("R4 commit");
    check("R4 fast", {7'd0, fastSpeed}, 8'd1);
    #1 check("R4 read", rdData, 8'hfe);
    // R9: mux at double speed
    drive(1, 0, 0, 0, 8'h00, 0, 1, 1); cycle("R9 fast base");
    drive(0, 1, 0, 0, 8'h00, 0, 1, 1); cycle("R9 fast dbl");
    // R5: stop without arm
    drive(0, 1, 1, 0, 8'h00, 1, 1, 1); cycle("R5 noarm");
    // R8: write arm=1 with commit on the same edge
    drive(0, 1, 1, 1, 8'h01, 0, 1, 1); cycle("R8 prearm");
    drive(0, 1, 1, 1, 8'h01, 1, 1, 1); cycle("R8 clash");
    #1 check("R8 arm cleared", rdData, 8'h7e);
    // R7: gating
    drive(0, 1, 1, 1, 8'h01, 0, 0, 1); cycle("R7 model off");
    drive(0, 1, 1, 1, 8'h01, 1, 1, 0); cycle("R7 mode off");
    #1 check("R7 read ff", rdData, 8'hff);
    drive(0, 0, 1, 0, 8'h00, 0, 1, 1); cycle("R7 after");
    check("R7 arm kept", rdData, 8'h7e);
    // R10: no select
    drive(0, 0, 0, 0, 8'h00, 0, 1, 1); #1 check("R10 nosel", rdData, 8'hff);
    @(negedge clk);
    for (int i = 0; i < 1500; i++) begin
      drive($urandom % 2, $urandom % 2, ($urandom % 4) != 0, $urandom % 2,
            8'($urandom), ($urandom % 3) == 0, ($urandom % 8) != 0,
            ($urandom % 8) != 0);
      cycle("RND");
    end
    // R1: reset mid-run
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1; mSpeed = 1'b0; mArm = 1'b0;
    drive(0, 0, 1, 0, 8'h00, 0, 1, 1);
    #1 check("R1 rerst read", rdData, 8'h7e);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule